// File: doc/BRIEF.md
# USB Device Endpoint Transaction Sequencer

This block steers one device endpoint through the token, data and handshake phases of a bus transaction. Upstream logic hands it decoded token PIDs, received data PIDs with a CRC verdict, and received handshake PIDs. Endpoint-level status comes in as three levels: buffer ready, halted and isochronous. The block decides whether incoming data is kept or thrown away and which handshake goes back. For IN tokens it picks the data PID to send. It also owns the DATA0/DATA1 sequence bit.

Outputs are a one-cycle transmit request carrying a PID, plus one-cycle strobes that tell the buffer logic to commit or drop the current packet. Control transfers are handled specially. A SETUP is always accepted and always loads DATA1 for the data stage. A status-stage flag forces DATA1 for that stage. Isochronous traffic runs with two phases and never produces or waits for a handshake.

Top module: `ep_txn_seq`

## Requirements
- R1: After reset no transmit request or buffer strobe is active and the sequence bit (`data_toggle`) reads 0.
- R2: An OUT data packet with good CRC whose PID matches the sequence bit (DATA0 = 4'h3, DATA1 = 4'hB) arrives on a ready, non-halted endpoint. One cycle later the block sends ACK (4'h2), pulses commit and inverts the sequence bit. Commit and discard are never active together.
- R3: An OUT data packet with good CRC on a halted endpoint draws STALL (4'hE). One on a ready-low, non-halted endpoint draws NAK (4'hA). In both cases the block pulses discard and keeps the sequence bit.
- R4: An OUT data packet with good CRC whose PID disagrees with the sequence bit is answered with ACK. The block pulses discard and keeps the sequence bit.
- R5: A data packet with bad CRC gets no handshake. The block pulses discard and keeps the sequence bit.
- R6: SETUP (token 4'hD) with good CRC is answered with ACK and commit whatever the halted and ready inputs say, and the sequence bit becomes 1. It never produces NAK or STALL. A SETUP with bad CRC draws no handshake and a discard.
- R7: An IN token (4'h9) on a non-isochronous endpoint is answered one cycle later. A halted endpoint sends STALL. A ready-low endpoint sends NAK. Otherwise the block sends DATA0 or DATA1 according to the sequence bit.
- R8: After IN data is sent, an ACK from the host within HS_TIMEOUT cycles pulses commit and inverts the sequence bit. A timeout or any other handshake PID leaves the bit alone, so a retry resends the same data PID.
- R9: On an isochronous endpoint no handshake is ever sent. OUT data commits when the CRC is good and the buffer is ready, and is discarded otherwise. IN always sends DATA0 and commits only when ready. The sequence bit is untouched.
- R10: A token presented with `ctl_status` high sets the sequence bit to 1 before that transaction runs.
- R11: A token always starts a new transaction, even while a data packet or handshake is still awaited. Data packets and handshakes arriving when nothing is awaited have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Decoded token present this cycle |
| tok_pid | input | 4 | Token PID: OUT, IN or SETUP |
| ctl_status | input | 1 | Token begins a control status stage |
| rx_data_valid | input | 1 | Received data packet completed this cycle |
| rx_data_pid | input | 4 | PID of the received data packet |
| rx_data_ok | input | 1 | CRC of the received data packet was good |
| rx_hs_valid | input | 1 | Received handshake this cycle |
| rx_hs_pid | input | 4 | PID of the received handshake |
| ep_ready | input | 1 | Endpoint buffer can take or supply data |
| ep_halted | input | 1 | Endpoint halted |
| ep_iso | input | 1 | Endpoint is isochronous |
| tx_req | output | 1 | One-cycle request to transmit `tx_pid` |
| tx_pid | output | 4 | PID to transmit (data or handshake) |
| buf_commit | output | 1 | Keep received data / release sent data |
| buf_discard | output | 1 | Drop received data |
| data_toggle | output | 1 | Current sequence bit |

## Verification
The assertions assume that `ep_iso` and the SETUP flag do not change during a transaction. They also assume that the upstream decoder never presents a SETUP on an isochronous endpoint. Under those conditions, a transmit that follows an isochronous decision can only be DATA0. The stimulus sets the endpoint status levels together with the token and holds them until the transaction ends. It sends SETUP only with the isochronous flag low. It never pulses a token, a data packet and a handshake in the same cycle, except in the deliberate pre-emption and idle-noise cases.

// File: rtl/ep_seq_pkg.sv
package ep_seq_pkg;

   typedef enum logic [3:0] {
      PID_OUT   = 4'h1,
      PID_IN    = 4'h9,
      PID_SETUP = 4'hD,
      PID_DATA0 = 4'h3,
      PID_DATA1 = 4'hB,
      PID_ACK   = 4'h2,
      PID_NAK   = 4'hA,
      PID_STALL = 4'hE
   } pid_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RX_DATA,
      ST_HS_WAIT
   } seq_state_e;

   typedef struct packed {
      logic       send;
      logic [3:0] pid;
      logic       commit;
      logic       discard;
      logic       flip;
      logic       set_one;
   } verdict_t;

   function automatic logic [3:0] data_pid_of(input logic tog);
      return tog ? PID_DATA1 : PID_DATA0;
   endfunction

endpackage

// File: rtl/ep_seq_toggle.sv
module ep_seq_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic force_one,
   input  logic flip,
   output logic tog
);

   always_ff @(posedge clk) begin
      if (!rst_n)         tog <= 1'b0;
      else if (force_one) tog <= 1'b1;
      else if (flip)      tog <= ~tog;
   end

   // R6 / R10: forcing takes priority and always lands on DATA1
   assert_force_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
      force_one |=> tog);

   // R2 / R8: a plain flip inverts the bit
   assert_flip_inverts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (flip && !force_one) |=> (tog != $past(tog)));

   // R3 / R4 / R5: no request, no change
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!flip && !force_one) |=> $stable(tog));

endmodule

// File: rtl/ep_seq_wait_timer.sv
module ep_seq_wait_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clear,
   output logic expired
);

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("ep_seq_wait_timer: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt <= '0;
      else if (!run || clear)   cnt <= '0;
      else if (cnt != LAST)     cnt <= cnt + 1'b1;
   end

   assign expired = run && !clear && (cnt == LAST);

   // R8: while waiting the count advances by one each cycle until expiry
   assert_timer_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clear && !expired) |=> (!run || clear || cnt == CW'($past(cnt) + 1'b1)));

endmodule

// File: rtl/ep_seq_out_judge.sv
module ep_seq_out_judge
   import ep_seq_pkg::*;
(
   input  logic       is_setup,
   input  logic       is_iso,
   input  logic       halted,
   input  logic       ready,
   input  logic       crc_ok,
   input  logic [3:0] rx_pid,
   input  logic       exp_tog,
   output verdict_t   v
);

   always_comb begin
      v     = '0;
      v.pid = PID_ACK;
      if (is_setup) begin
         if (crc_ok) begin
            v.send    = 1'b1;
            v.commit  = 1'b1;
            v.set_one = 1'b1;
         end else begin
            v.discard = 1'b1;
         end
      end else if (is_iso) begin
         if (crc_ok && ready) v.commit  = 1'b1;
         else                 v.discard = 1'b1;
      end else if (!crc_ok) begin
         v.discard = 1'b1;
      end else if (halted) begin
         v.send    = 1'b1;
         v.pid     = PID_STALL;
         v.discard = 1'b1;
      end else if (!ready) begin
         v.send    = 1'b1;
         v.pid     = PID_NAK;
         v.discard = 1'b1;
      end else if (rx_pid != data_pid_of(exp_tog)) begin
         v.send    = 1'b1;
         v.discard = 1'b1;
      end else begin
         v.send    = 1'b1;
         v.commit  = 1'b1;
         v.flip    = 1'b1;
      end
   end

endmodule

// File: rtl/ep_txn_seq.sv
module ep_txn_seq
   import ep_seq_pkg::*;
#(
   parameter int HS_TIMEOUT = 16,
   parameter bit ISO_EN     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tok_valid,
   input  logic [3:0] tok_pid,
   input  logic       ctl_status,
   input  logic       rx_data_valid,
   input  logic [3:0] rx_data_pid,
   input  logic       rx_data_ok,
   input  logic       rx_hs_valid,
   input  logic [3:0] rx_hs_pid,
   input  logic       ep_ready,
   input  logic       ep_halted,
   input  logic       ep_iso,
   output logic       tx_req,
   output logic [3:0] tx_pid,
   output logic       buf_commit,
   output logic       buf_discard,
   output logic       data_toggle
);

   localparam int PID_W = 4;

   logic iso_eff;
   if (ISO_EN) begin : g_iso
      assign iso_eff = ep_iso;
   end else begin : g_no_iso
      logic unused_iso;
      assign unused_iso = ep_iso;
      assign iso_eff    = 1'b0;
   end

   seq_state_e state, nxt;
   logic       setup_q, nxt_setup;
   logic       s_send, s_commit, s_discard;
   logic [PID_W-1:0] s_pid;
   logic       t_flip, t_force;
   logic       tog, tog_eff, expired;
   verdict_t   verdict;

   ep_seq_toggle u_toggle (
      .clk       (clk),
      .rst_n     (rst_n),
      .force_one (t_force),
      .flip      (t_flip),
      .tog       (tog)
   );

   ep_seq_wait_timer #(.LIMIT(HS_TIMEOUT)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state != ST_IDLE),
      .clear   (tok_valid),
      .expired (expired)
   );

   ep_seq_out_judge u_judge (
      .is_setup (setup_q),
      .is_iso   (iso_eff),
      .halted   (ep_halted),
      .ready    (ep_ready),
      .crc_ok   (rx_data_ok),
      .rx_pid   (rx_data_pid),
      .exp_tog  (tog),
      .v        (verdict)
   );

   assign tog_eff = tog | (tok_valid & ctl_status);

   always_comb begin
      nxt       = state;
      nxt_setup = setup_q;
      s_send    = 1'b0;
      s_pid     = PID_ACK;
      s_commit  = 1'b0;
      s_discard = 1'b0;
      t_flip    = 1'b0;
      t_force   = tok_valid & ctl_status;
      if (tok_valid) begin
         nxt = ST_IDLE;
         if (tok_pid == PID_IN) begin
            if (iso_eff) begin
               s_send   = 1'b1;
               s_pid    = PID_DATA0;
               s_commit = ep_ready;
            end else if (ep_halted) begin
               s_send = 1'b1;
               s_pid  = PID_STALL;
            end else if (!ep_ready) begin
               s_send = 1'b1;
               s_pid  = PID_NAK;
            end else begin
               s_send = 1'b1;
               s_pid  = data_pid_of(tog_eff);
               nxt    = ST_HS_WAIT;
            end
         end else if (tok_pid == PID_OUT) begin
            nxt       = ST_RX_DATA;
            nxt_setup = 1'b0;
         end else if (tok_pid == PID_SETUP) begin
            nxt       = ST_RX_DATA;
            nxt_setup = 1'b1;
         end
      end else begin
         case (state)
            ST_RX_DATA: begin
               if (rx_data_valid) begin
                  s_send    = verdict.send;
                  s_pid     = verdict.pid;
                  s_commit  = verdict.commit;
                  s_discard = verdict.discard;
                  t_flip    = verdict.flip;
                  t_force   = verdict.set_one;
                  nxt       = ST_IDLE;
               end else if (expired) begin
                  nxt = ST_IDLE;
               end
            end
            ST_HS_WAIT: begin
               if (rx_hs_valid) begin
                  if (rx_hs_pid == PID_ACK) begin
                     t_flip   = 1'b1;
                     s_commit = 1'b1;
                  end
                  nxt = ST_IDLE;
               end else if (expired) begin
                  nxt = ST_IDLE;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         setup_q     <= 1'b0;
         tx_req      <= 1'b0;
         tx_pid      <= PID_ACK;
         buf_commit  <= 1'b0;
         buf_discard <= 1'b0;
      end else begin
         state       <= nxt;
         setup_q     <= nxt_setup;
         tx_req      <= s_send;
         tx_pid      <= s_pid;
         buf_commit  <= s_commit;
         buf_discard <= s_discard;
      end
   end

   assign data_toggle = tog;

   // R2: the two buffer strobes never coincide
   assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(buf_commit && buf_discard));

   // R6: a clean SETUP is always acknowledged and leaves DATA1 behind
   assert_setup_acked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RX_DATA && setup_q && rx_data_valid && rx_data_ok && !tok_valid)
      |=> (tx_req && tx_pid == PID_ACK && data_toggle));

   // R7: IN on an idle-buffer, non-halted bulk endpoint draws NAK
   assert_in_nak_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_pid == PID_IN && !iso_eff && !ep_halted && !ep_ready)
      |=> (tx_req && tx_pid == PID_NAK));

   // R9: isochronous decisions only ever transmit DATA0, never a handshake
   assert_iso_no_hs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && $past(iso_eff) && !$past(setup_q)) |-> (tx_pid == PID_DATA0));

endmodule

// File: tb/ep_txn_seq_test.sv
module ep_txn_seq_test;

   localparam int HS_TIMEOUT = 16;
   localparam time HALF = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tok_valid = 1'b0;
   logic [3:0] tok_pid = 4'h0;
   logic       ctl_status = 1'b0;
   logic       rx_data_valid = 1'b0;
   logic [3:0] rx_data_pid = 4'h0;
   logic       rx_data_ok = 1'b0;
   logic       rx_hs_valid = 1'b0;
   logic [3:0] rx_hs_pid = 4'h0;
   logic       ep_ready = 1'b0;
   logic       ep_halted = 1'b0;
   logic       ep_iso = 1'b0;
   logic       tx_req, buf_commit, buf_discard, data_toggle;
   logic [3:0] tx_pid;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int         got_tx;
   logic [3:0] got_pid;
   logic       got_c, got_d;

   always #HALF clk = ~clk;

   ep_txn_seq #(.HS_TIMEOUT(HS_TIMEOUT), .ISO_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n),
      .tok_valid(tok_valid), .tok_pid(tok_pid), .ctl_status(ctl_status),
      .rx_data_valid(rx_data_valid), .rx_data_pid(rx_data_pid), .rx_data_ok(rx_data_ok),
      .rx_hs_valid(rx_hs_valid), .rx_hs_pid(rx_hs_pid),
      .ep_ready(ep_ready), .ep_halted(ep_halted), .ep_iso(ep_iso),
      .tx_req(tx_req), .tx_pid(tx_pid),
      .buf_commit(buf_commit), .buf_discard(buf_discard), .data_toggle(data_toggle)
   );

   typedef struct packed {
      logic [3:0] tok;
      logic       stat;
      logic [3:0] dpid;
      logic       crc;
      logic       rdy;
      logic       hlt;
      logic       iso;
      logic [3:0] hs;       // 0: host sends no handshake
      logic [3:0] exp_pid;  // 0: nothing transmitted
      logic       exp_c;
      logic       exp_d;
      logic       exp_tog;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      '{4'h1,1'b0,4'h3,1'b1,1'b1,1'b0,1'b0,4'h0, 4'h2,1'b1,1'b0,1'b1, 4'd2},  // R2 DATA0 accepted
      '{4'h1,1'b0,4'hB,1'b1,1'b1,1'b0,1'b0,4'h0, 4'h2,1'b1,1'b0,1'b0, 4'd2},  // R2 DATA1 accepted
      '{4'h1,1'b0,4'hB,1'b1,1'b1,1'b0,1'b0,4'h0, 4'h2,1'b0,1'b1,1'b0, 4'd4},  // R4 mismatch
      '{4'h1,1'b0,4'h3,1'b1,1'b0,1'b0,1'b0,4'h0, 4'hA,1'b0,1'b1,1'b0, 4'd3},  // R3 NAK
      '{4'h1,1'b0,4'h3,1'b1,1'b1,1'b1,1'b0,4'h0, 4'hE,1'b0,1'b1,1'b0, 4'd3},  // R3 STALL
      '{4'h1,1'b0,4'h3,1'b0,1'b1,1'b0,1'b0,4'h0, 4'h0,1'b0,1'b1,1'b0, 4'd5},  // R5 bad CRC
      '{4'h9,1'b0,4'h0,1'b1,1'b1,1'b0,1'b0,4'h2, 4'h3,1'b1,1'b0,1'b1, 4'd7},  // R7 IN DATA0 + ACK
      '{4'h9,1'b0,4'h0,1'b1,1'b1,1'b0,1'b0,4'h0, 4'hB,1'b0,1'b0,1'b1, 4'd8},  // R8 timeout
      '{4'h9,1'b0,4'h0,1'b1,1'b1,1'b0,1'b0,4'h2, 4'hB,1'b1,1'b0,1'b0, 4'd8},  // R8 retry same PID
      '{4'h9,1'b0,4'h0,1'b1,1'b0,1'b0,1'b0,4'h0, 4'hA,1'b0,1'b0,1'b0, 4'd7},  // R7 NAK
      '{4'h9,1'b0,4'h0,1'b1,1'b1,1'b1,1'b0,4'h0, 4'hE,1'b0,1'b0,1'b0, 4'd7},  // R7 STALL
      '{4'hD,1'b0,4'h3,1'b1,1'b0,1'b1,1'b0,4'h0, 4'h2,1'b1,1'b0,1'b1, 4'd6},  // R6 SETUP despite halt
      '{4'h9,1'b0,4'h0,1'b1,1'b1,1'b0,1'b0,4'h2, 4'hB,1'b1,1'b0,1'b0, 4'd6},  // R6 data stage DATA1
      '{4'h1,1'b1,4'hB,1'b1,1'b1,1'b0,1'b0,4'h0, 4'h2,1'b1,1'b0,1'b0, 4'd10}, // R10 OUT status
      '{4'h9,1'b1,4'h0,1'b1,1'b1,1'b0,1'b0,4'h2, 4'hB,1'b1,1'b0,1'b0, 4'd10}, // R10 IN status
      '{4'h1,1'b0,4'h3,1'b1,1'b1,1'b0,1'b1,4'h0, 4'h0,1'b1,1'b0,1'b0, 4'd9},  // R9 iso OUT good
      '{4'h1,1'b0,4'h3,1'b0,1'b1,1'b0,1'b1,4'h0, 4'h0,1'b0,1'b1,1'b0, 4'd9},  // R9 iso OUT bad
      '{4'h9,1'b0,4'h0,1'b1,1'b0,1'b0,1'b1,4'h0, 4'h3,1'b0,1'b0,1'b0, 4'd9},  // R9 iso IN not ready
      '{4'h1,1'b0,4'h3,1'b1,1'b1,1'b0,1'b0,4'h0, 4'h2,1'b1,1'b0,1'b1, 4'd2},  // R2 bit to 1
      '{4'h9,1'b0,4'h0,1'b1,1'b1,1'b0,1'b1,4'h0, 4'h3,1'b1,1'b0,1'b1, 4'd9},  // R9 iso IN DATA0
      '{4'h9,1'b0,4'h0,1'b1,1'b1,1'b0,1'b0,4'hA, 4'hB,1'b0,1'b0,1'b1, 4'd8},  // R8 non-ACK reply
      '{4'hD,1'b0,4'h3,1'b0,1'b1,1'b0,1'b0,4'h0, 4'h0,1'b0,1'b1,1'b1, 4'd6}   // R6 SETUP bad CRC
   };

   task automatic check(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic clear_obs();
      got_tx = 0; got_pid = 4'h0; got_c = 1'b0; got_d = 1'b0;
   endtask

   task automatic step();
      @(negedge clk);
      if (tx_req === 1'b1) begin got_tx++; got_pid = tx_pid; end
      if (buf_commit === 1'b1) got_c = 1'b1;
      if (buf_discard === 1'b1) got_d = 1'b1;
   endtask

   task automatic run_vec(input vec_t v);
      string tag;
      tag = $sformatf("R%0d", v.req);
      clear_obs();
      tok_valid = 1'b1; tok_pid = v.tok; ctl_status = v.stat;
      ep_ready = v.rdy; ep_halted = v.hlt; ep_iso = v.iso;
      step();
      tok_valid = 1'b0; ctl_status = 1'b0;
      if (v.tok != 4'h9) begin
         rx_data_valid = 1'b1; rx_data_pid = v.dpid; rx_data_ok = v.crc;
         step();
         rx_data_valid = 1'b0;
      end else if (v.hs != 4'h0) begin
         rx_hs_valid = 1'b1; rx_hs_pid = v.hs;
         step();
         rx_hs_valid = 1'b0;
      end else begin
         repeat (HS_TIMEOUT + 3) step();
      end
      check(tag, "tx count", 4'(got_tx), (v.exp_pid != 4'h0) ? 4'd1 : 4'd0);
      if (v.exp_pid != 4'h0) check(tag, "tx pid", got_pid, v.exp_pid);
      check(tag, "commit", {3'b0, got_c}, {3'b0, v.exp_c});
      check(tag, "discard", {3'b0, got_d}, {3'b0, v.exp_d});
      check(tag, "toggle", {3'b0, data_toggle}, {3'b0, v.exp_tog});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", "tx_req", {3'b0, tx_req}, 4'd0);
      check("R1", "commit", {3'b0, buf_commit}, 4'd0);
      check("R1", "discard", {3'b0, buf_discard}, 4'd0);
      check("R1", "toggle", {3'b0, data_toggle}, 4'd0);

      for (int i = 0; i < NV; i++) run_vec(VEC[i]);

      // R11: stray data and handshake with nothing awaited (bit is 1 here)
      clear_obs();
      ep_iso = 1'b0; ep_ready = 1'b1; ep_halted = 1'b0;
      rx_data_valid = 1'b1; rx_data_pid = 4'hB; rx_data_ok = 1'b1;
      rx_hs_valid = 1'b1; rx_hs_pid = 4'h2;
      step();
      rx_data_valid = 1'b0; rx_hs_valid = 1'b0;
      step();
      check("R11", "idle tx", 4'(got_tx), 4'd0);
      check("R11", "idle commit", {3'b0, got_c}, 4'd0);
      check("R11", "idle discard", {3'b0, got_d}, 4'd0);
      check("R11", "idle toggle", {3'b0, data_toggle}, 4'd1);

      // R11: IN token pre-empts a pending OUT; later data is not judged
      clear_obs();
      tok_valid = 1'b1; tok_pid = 4'h1;
      step();
      tok_pid = 4'h9;
      step();
      tok_valid = 1'b0;
      rx_data_valid = 1'b1; rx_data_pid = 4'hB; rx_data_ok = 1'b1;
      step();
      rx_data_valid = 1'b0;
      rx_hs_valid = 1'b1; rx_hs_pid = 4'h2;
      step();
      rx_hs_valid = 1'b0;
      check("R11", "preempt tx count", 4'(got_tx), 4'd1);
      check("R11", "preempt tx pid", got_pid, 4'hB);
      check("R11", "preempt commit", {3'b0, got_c}, 4'd1);
      check("R11", "preempt discard", {3'b0, got_d}, 4'd0);
      check("R11", "preempt toggle", {3'b0, data_toggle}, 4'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule